// File: doc/BRIEF.md
# Linked Descriptor Chain Walker

This block is a bus-master engine that walks a linked list of command descriptors held in memory. Each descriptor is three 32-bit words: the data buffer address, the address of the next descriptor, and a control word. Once the control word has been read, the engine announces the lane mode, direction, hold flag and byte length to the serial engine. It then moves the described data one full word at a time. In the write direction it reads memory and streams words out. In the read direction it takes words in and stores them to memory. After that it either follows the next pointer or ends the chain.

Software starts a chain by supplying the first descriptor address on a start strobe. While the chain runs, the address of the descriptor being worked on and the address of the next data word are visible at the ports. The end of a chain sets a done bit in a write-one-to-clear interrupt status word. A failed memory access instead sets an error bit and abandons the chain. Memory is reached through a simple request/acknowledge port with one access outstanding at a time.

Top module: `dcw_chain_walker`

## Requirements
- R1: After reset the block is idle (busy low), makes no memory request, drives no stream handshakes, and the interrupt status is zero with irq low.
- R2: A start strobe while idle fetches three words with reads, in this order: start address, start address + 4 and start address + 8. These are the data address, the next-descriptor address and the control word.
- R3: The control word is decoded as follows: bit 0 is the direction (1 = memory to serial, 0 = serial to memory), bits [3:1] are the lane mode, bit 8 is the hold (continue) flag and bits [31:16] are the byte length. The fields are shown for one cycle on cfg_valid before any data of that descriptor moves.
- R4: In the memory-to-serial direction, ceil(length/4) words are read from ascending addresses starting at the data address. They are offered on the tx stream in that order, with tx_last set only on the final word.
- R5: In the serial-to-memory direction, each accepted rx word is written to memory as a full 32-bit word, at ascending addresses from the data address. Exactly ceil(length/4) words are written, so memory past that range is untouched.
- R6: A descriptor with the hold flag set is followed by fetching the descriptor at its next-descriptor address. cfg_hold reports the flag so that chip select can stay asserted across descriptors.
- R7: A descriptor with the hold flag clear ends the chain after its data. Its next pointer is not fetched, busy falls, and status bit 31 is set in the same cycle.
- R8: A length of zero moves no data words, and the chain goes on according to the hold flag.
- R9: A memory acknowledge flagged as an error sets status bit 3, returns the block to idle, and does not set status bit 31.
- R10: Status bits are cleared by writing ones on int_clr, and a set in the same cycle takes priority over the clear. irq is high whenever any status bit is set.
- R11: A start strobe while busy is ignored.
- R12: cur_desc_addr holds the address of the current descriptor. cur_mem_addr holds the address of the next data word, so after a descriptor finishes it equals the data address + 4 × words moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Start strobe carrying the first descriptor address |
| start_addr | input | AW | Address of the first descriptor |
| int_clr | input | 32 | Write-one-to-clear mask for the status word |
| int_status | output | 32 | Status: bit 31 chain done, bit 3 bus error |
| irq | output | 1 | Any status bit set |
| busy | output | 1 | A chain is being processed |
| cur_desc_addr | output | AW | Address of the current descriptor |
| cur_mem_addr | output | AW | Address of the next data word |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Completed request failed (valid with mem_ack) |
| mem_rdata | input | 32 | Read data (valid with mem_ack) |
| cfg_valid | output | 1 | One-cycle descriptor announcement |
| cfg_dir | output | 1 | Direction of the descriptor |
| cfg_mode | output | 3 | Lane mode of the descriptor |
| cfg_hold | output | 1 | Keep chip select after this descriptor |
| cfg_len | output | 16 | Byte length of the descriptor |
| tx_valid | output | 1 | Outgoing data word valid |
| tx_ready | input | 1 | Serial engine takes the word |
| tx_data | output | 32 | Outgoing data word |
| tx_last | output | 1 | Final word of the descriptor |
| rx_valid | input | 1 | Incoming data word valid |
| rx_ready | output | 1 | Block takes the incoming word |
| rx_data | input | 32 | Incoming data word |

## Verification
The bench uses the default 32-bit address width, so descriptor and data addresses are ordinary byte addresses within a small word-indexed memory model. That model acknowledges every access one cycle after the request and can fail the access at one chosen address. These choices allow exact checks of odd lengths rounding up to whole words, a sentinel word just past a serial-to-memory buffer, zero-length descriptors inside a chain, and an error partway through a buffer. The 16-bit length field stays at its full width. Short lengths are used so that every data word can be compared.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

  localparam int WORD_BYTES = 4;
  localparam int LEN_W      = 16;
  localparam int ST_W       = 32;
  localparam int ST_DONE    = 31;
  localparam int ST_BUSERR  = 3;

  // control word field positions (decoded by the serial side as well)
  localparam int F_DIR      = 0;
  localparam int F_MODE_LO  = 1;
  localparam int F_HOLD     = 8;
  localparam int F_LEN_LO   = 16;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             hold;
    logic [2:0]       mode;
    logic             dir;
  } dcw_ctrl_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_FETCH_DATA,
    S_FETCH_NEXT,
    S_FETCH_CTRL,
    S_ANNOUNCE,
    S_MEM_RD,
    S_TX,
    S_RX,
    S_MEM_WR,
    S_STEP
  } dcw_state_e;

  function automatic dcw_ctrl_t dcw_unpack(input logic [31:0] w);
    dcw_ctrl_t c;
    c.dir  = w[F_DIR];
    c.mode = w[F_MODE_LO +: 3];
    c.hold = w[F_HOLD];
    c.len  = w[F_LEN_LO +: LEN_W];
    return c;
  endfunction

  // whole words covering len bytes
  function automatic logic [LEN_W-1:0] dcw_words(input logic [LEN_W-1:0] len);
    logic [LEN_W:0] s;
    s = {1'b0, len} + (LEN_W+1)'(WORD_BYTES - 1);
    return {1'b0, s[LEN_W:2]};
  endfunction

endpackage

// File: rtl/dcw_ctrl_decode.sv
module dcw_ctrl_decode
  import dcw_pkg::*;
(
  input  logic [31:0]      word,
  output dcw_ctrl_t        ctrl,
  output logic [LEN_W-1:0] words
);
  always_comb begin
    ctrl  = dcw_unpack(word);
    words = dcw_words(ctrl.len);
  end
endmodule

// File: rtl/dcw_cursor.sv
module dcw_cursor
  import dcw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    load_ptr,
  input  logic [LEN_W-1:0] load_words,
  input  logic             step,
  output logic [AW-1:0]    ptr,
  output logic [LEN_W-1:0] left,
  output logic             is_last,
  output logic             empty
);
  localparam logic [AW-1:0] STRIDE = AW'(WORD_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      left <= '0;
    end else if (load) begin
      ptr  <= load_ptr;
      left <= load_words;
    end else if (step) begin
      ptr  <= ptr + STRIDE;
      left <= left - 1'b1;
    end
  end

  assign is_last = (left == LEN_W'(1));
  assign empty   = (left == '0);
endmodule

// File: rtl/dcw_status.sv
module dcw_status
  import dcw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_done,
  input  logic            set_err,
  input  logic [ST_W-1:0] clr,
  output logic [ST_W-1:0] status,
  output logic            irq
);
  logic [ST_W-1:0] set_vec;

  always_comb begin
    set_vec            = '0;
    set_vec[ST_DONE]   = set_done;
    set_vec[ST_BUSERR] = set_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr) | set_vec;
  end

  assign irq = |status;
endmodule

// File: rtl/dcw_chain_walker.sv
module dcw_chain_walker
  import dcw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_valid,
  input  logic [AW-1:0] start_addr,
  input  logic [31:0]   int_clr,
  output logic [31:0]   int_status,
  output logic          irq,
  output logic          busy,
  output logic [AW-1:0] cur_desc_addr,
  output logic [AW-1:0] cur_mem_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [31:0]   mem_rdata,
  output logic          cfg_valid,
  output logic          cfg_dir,
  output logic [2:0]    cfg_mode,
  output logic          cfg_hold,
  output logic [15:0]   cfg_len,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [31:0]   tx_data,
  output logic          tx_last,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [31:0]   rx_data
);
  localparam logic [AW-1:0] OFS_NEXT = AW'(WORD_BYTES);
  localparam logic [AW-1:0] OFS_CTRL = AW'(2 * WORD_BYTES);

  dcw_state_e       state, state_nx;
  logic [AW-1:0]    desc_q, data_base_q, next_q;
  dcw_ctrl_t        ctrl_q, ctrl_dec;
  logic [LEN_W-1:0] words_dec;
  logic [31:0]      buf_q;

  // named events
  logic acc_ok, acc_fail, tx_fire, rx_fire, chain_end, go;
  logic cur_load, cur_step, cur_last, cur_empty;
  logic [LEN_W-1:0] cur_left;

  assign acc_ok    = mem_req && mem_ack && !mem_err;
  assign acc_fail  = mem_req && mem_ack && mem_err;
  assign tx_fire   = tx_valid && tx_ready;
  assign rx_fire   = rx_valid && rx_ready;
  assign chain_end = (state == S_STEP) && !ctrl_q.hold;
  assign go        = (state == S_IDLE) && start_valid;

  dcw_ctrl_decode u_dec (
    .word  (mem_rdata),
    .ctrl  (ctrl_dec),
    .words (words_dec)
  );

  assign cur_load = (state == S_FETCH_CTRL) && acc_ok;
  assign cur_step = ((state == S_TX) && tx_fire) ||
                    ((state == S_MEM_WR) && acc_ok);

  dcw_cursor #(.AW(AW)) u_cur (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cur_load),
    .load_ptr   (data_base_q),
    .load_words (words_dec),
    .step       (cur_step),
    .ptr        (cur_mem_addr),
    .left       (cur_left),
    .is_last    (cur_last),
    .empty      (cur_empty)
  );

  dcw_status u_st (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_done (chain_end),
    .set_err  (acc_fail),
    .clr      (int_clr),
    .status   (int_status),
    .irq      (irq)
  );

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE:       if (start_valid) state_nx = S_FETCH_DATA;
      S_FETCH_DATA: if (acc_ok) state_nx = S_FETCH_NEXT;
      S_FETCH_NEXT: if (acc_ok) state_nx = S_FETCH_CTRL;
      S_FETCH_CTRL: if (acc_ok) state_nx = S_ANNOUNCE;
      S_ANNOUNCE: begin
        if (cur_empty)       state_nx = S_STEP;
        else if (ctrl_q.dir) state_nx = S_MEM_RD;
        else                 state_nx = S_RX;
      end
      S_MEM_RD:     if (acc_ok) state_nx = S_TX;
      S_TX:         if (tx_fire) state_nx = cur_last ? S_STEP : S_MEM_RD;
      S_RX:         if (rx_fire) state_nx = S_MEM_WR;
      S_MEM_WR:     if (acc_ok) state_nx = cur_last ? S_STEP : S_RX;
      S_STEP:       state_nx = ctrl_q.hold ? S_FETCH_DATA : S_IDLE;
      default:      state_nx = S_IDLE;
    endcase
    if (acc_fail) state_nx = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      desc_q      <= '0;
      data_base_q <= '0;
      next_q      <= '0;
      ctrl_q      <= '0;
      buf_q       <= '0;
    end else begin
      state <= state_nx;
      if (go) desc_q <= start_addr;
      if ((state == S_STEP) && ctrl_q.hold) desc_q <= next_q;
      if ((state == S_FETCH_DATA) && acc_ok) data_base_q <= mem_rdata;
      if ((state == S_FETCH_NEXT) && acc_ok) next_q <= mem_rdata;
      if (cur_load) ctrl_q <= ctrl_dec;
      if ((state == S_MEM_RD) && acc_ok) buf_q <= mem_rdata;
      if (rx_fire) buf_q <= rx_data;
    end
  end

  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = cur_mem_addr;
    case (state)
      S_FETCH_DATA: begin mem_req = 1'b1; mem_addr = desc_q; end
      S_FETCH_NEXT: begin mem_req = 1'b1; mem_addr = desc_q + OFS_NEXT; end
      S_FETCH_CTRL: begin mem_req = 1'b1; mem_addr = desc_q + OFS_CTRL; end
      S_MEM_RD:     mem_req = 1'b1;
      S_MEM_WR:     begin mem_req = 1'b1; mem_we = 1'b1; end
      default: ;
    endcase
  end

  assign mem_wdata     = buf_q;
  assign busy          = (state != S_IDLE);
  assign cur_desc_addr = desc_q;
  assign cfg_valid     = (state == S_ANNOUNCE);
  assign cfg_dir       = ctrl_q.dir;
  assign cfg_mode      = ctrl_q.mode;
  assign cfg_hold      = ctrl_q.hold;
  assign cfg_len       = ctrl_q.len;
  assign tx_valid      = (state == S_TX);
  assign tx_data       = buf_q;
  assign tx_last       = (state == S_TX) && cur_last;
  assign rx_ready      = (state == S_RX);

  logic unused_ok;
  assign unused_ok = ^cur_left;
endmodule

// File: rtl/dcw_chain_walker_chk.sv
module dcw_chain_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_err,
  input logic [AW-1:0] mem_addr,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [31:0]   tx_data,
  input logic          rx_ready,
  input logic [31:0]   int_status,
  input logic          irq
);
  a_r1_idle_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !tx_valid && !rx_ready);

  a_r2_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  a_r4_tx_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  a_r5_rx_not_during_write: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !mem_req);

  a_r7_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_status[31]) |-> !busy);

  a_r9_error_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_err |=> !busy && int_status[3] && !$rose(int_status[31]));

  a_r10_irq_tracks_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (int_status != 32'd0));
endmodule

bind dcw_chain_walker dcw_chain_walker_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_dcw_chain_walker.sv
module tb_dcw_chain_walker;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          start_valid = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [31:0]   int_clr = '0;
  logic [31:0]   int_status;
  logic          irq, busy;
  logic [AW-1:0] cur_desc_addr, cur_mem_addr;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic          mem_ack, mem_err;
  logic [31:0]   mem_rdata;
  logic          cfg_valid, cfg_dir, cfg_hold;
  logic [2:0]    cfg_mode;
  logic [15:0]   cfg_len;
  logic          tx_valid, tx_last, rx_ready;
  logic          tx_ready = 1'b1;
  logic [31:0]   tx_data;
  logic          rx_valid = 1'b1;
  logic [31:0]   rx_data;

  dcw_chain_walker #(.AW(AW)) dut (.*);

  // memory model and capture (single owner of its state)
  logic [31:0] mem [0:1023];
  logic        poke_en = 1'b0;
  logic [31:0] poke_a = '0, poke_d = '0;
  logic        err_en = 1'b0;
  logic [31:0] err_a = '0;
  logic        cap_clr = 1'b0;
  int          tx_cnt, cfg_cnt, rx_idx, last_pos;
  logic [31:0] tx_w [0:15];
  logic        cfg_hold0, cfg_hold1;
  logic [15:0] cfg_len0;
  logic [3:0]  cfg_mode0;

  assign rx_data = 32'hA500_0000 + rx_idx;

  always @(posedge clk) begin
    if (poke_en) mem[poke_a[11:2]] <= poke_d;
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      mem_err <= mem_req && !mem_ack && err_en && (mem_addr == err_a);
      if (mem_req && !mem_ack) begin
        mem_rdata <= mem[mem_addr[11:2]];
        if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      end
    end
    if (cap_clr) begin
      tx_cnt <= 0; cfg_cnt <= 0; rx_idx <= 0; last_pos <= -1;
    end else begin
      if (tx_valid && tx_ready) begin
        tx_w[tx_cnt[3:0]] <= tx_data;
        if (tx_last) last_pos <= tx_cnt;
        tx_cnt <= tx_cnt + 1;
      end
      if (rx_valid && rx_ready) rx_idx <= rx_idx + 1;
      if (cfg_valid) begin
        if (cfg_cnt == 0) begin
          cfg_hold0 <= cfg_hold; cfg_len0 <= cfg_len; cfg_mode0 <= {cfg_dir, cfg_mode};
        end
        cfg_hold1 <= cfg_hold;
        cfg_cnt <= cfg_cnt + 1;
      end
    end
  end

  int checks = 0, failures = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); poke_en = 1'b1; poke_a = a; poke_d = d;
    @(negedge clk); poke_en = 1'b0;
  endtask

  function automatic logic [31:0] ctl(input bit dir, input logic [2:0] mode,
                                      input bit hold, input logic [15:0] len);
    return {len, 7'd0, hold, 4'd0, mode, dir};
  endfunction

  task automatic desc(input logic [31:0] at, input logic [31:0] data,
                      input logic [31:0] nxt, input logic [31:0] c);
    poke(at, data); poke(at + 4, nxt); poke(at + 8, c);
  endtask

  task automatic clear_caps();
    @(negedge clk); cap_clr = 1'b1; int_clr = '1;
    @(negedge clk); cap_clr = 1'b0; int_clr = '0;
  endtask

  task automatic run(input logic [31:0] a);
    @(negedge clk); start_valid = 1'b1; start_addr = a;
    @(negedge clk); start_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy", 32'(busy), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 status", int_status, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_single_tx();
    clear_caps();
    for (int i = 0; i < 4; i++) poke(32'h400 + 4*i, 32'h1111_0000 + i);
    desc(32'h100, 32'h400, 32'h200, ctl(1, 3'd3, 0, 16'd10));
    desc(32'h200, 32'h500, 32'h0, ctl(1, 3'd1, 0, 16'd4));
    run(32'h100);
    chk("R3 mode+dir", 32'(cfg_mode0), 32'hB);
    chk("R3 len", 32'(cfg_len0), 10);
    chk("R4 word count", tx_cnt, 3);
    for (int i = 0; i < 3; i++) chk("R4 word data", tx_w[i], 32'h1111_0000 + i);
    chk("R4 last position", last_pos, 2);
    chk("R7 next ignored", cfg_cnt, 1);
    chk("R7 done bit", int_status, 32'h8000_0000);
    chk("R10 irq", 32'(irq), 1);
    chk("R12 cur_mem_addr", cur_mem_addr, 32'h40C);
    chk("R12 cur_desc_addr", cur_desc_addr, 32'h100);
  endtask

  task automatic t_chain_rx();
    clear_caps();
    poke(32'h708, 32'hDEAD_BEEF);
    desc(32'h200, 32'h600, 32'h300, ctl(0, 3'd2, 1, 16'd8));
    desc(32'h300, 32'h700, 32'h900, ctl(0, 3'd2, 0, 16'd5));
    run(32'h200);
    chk("R6 descriptors", cfg_cnt, 2);
    chk("R6 hold first", 32'(cfg_hold0), 1);
    chk("R6 hold last", 32'(cfg_hold1), 0);
    chk("R5 word0", mem[32'h600 >> 2], 32'hA500_0000);
    chk("R5 word1", mem[32'h604 >> 2], 32'hA500_0001);
    chk("R5 word2", mem[32'h700 >> 2], 32'hA500_0002);
    chk("R5 word3", mem[32'h704 >> 2], 32'hA500_0003);
    chk("R5 sentinel", mem[32'h708 >> 2], 32'hDEAD_BEEF);
    chk("R12 cur_desc_addr", cur_desc_addr, 32'h300);
    chk("R12 cur_mem_addr", cur_mem_addr, 32'h708);
    chk("R7 done", int_status, 32'h8000_0000);
  endtask

  task automatic t_zero_len();
    clear_caps();
    poke(32'hB40, 32'hCAFE_0001);
    desc(32'hA00, 32'hB00, 32'hA40, ctl(1, 3'd1, 1, 16'd0));
    desc(32'hA40, 32'hB40, 32'h0, ctl(1, 3'd1, 0, 16'd4));
    run(32'hA00);
    chk("R8 descriptors", cfg_cnt, 2);
    chk("R8 first len", 32'(cfg_len0), 0);
    chk("R8 words moved", tx_cnt, 1);
    chk("R8 data", tx_w[0], 32'hCAFE_0001);
    chk("R12 cur_mem_addr", cur_mem_addr, 32'hB44);
  endtask

  task automatic t_bus_error();
    clear_caps();
    desc(32'h800, 32'h900, 32'h100, ctl(1, 3'd1, 1, 16'd8));
    @(negedge clk); err_en = 1'b1; err_a = 32'h904;
    run(32'h800);
    err_en = 1'b0;
    chk("R9 status", int_status, 32'h0000_0008);
    chk("R9 words before error", tx_cnt, 1);
    chk("R9 no further descriptor", cfg_cnt, 1);
    chk("R9 irq", 32'(irq), 1);
    @(negedge clk); int_clr = 32'h0000_0008;
    @(negedge clk); int_clr = '0;
    chk("R10 cleared", int_status, 0);
    chk("R10 irq low", 32'(irq), 0);
  endtask

  task automatic t_start_busy();
    clear_caps();
    @(negedge clk); start_valid = 1'b1; start_addr = 32'h100;
    @(negedge clk); start_valid = 1'b0;
    repeat (3) @(negedge clk);
    start_valid = 1'b1; start_addr = 32'h200;
    @(negedge clk); start_valid = 1'b0;
    while (busy) @(negedge clk);
    chk("R11 descriptors", cfg_cnt, 1);
    chk("R11 cur_desc_addr", cur_desc_addr, 32'h100);
    chk("R11 words", tx_cnt, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_tx();
    t_chain_rx();
    t_zero_len();
    t_bus_error();
    t_start_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule